// File: doc/BRIEF.md
# SDRAM Command Decoder with Bank State Tracking

This block sits on the device side of a double-data-rate SDRAM command bus. On every rising clock edge it captures the chip select, row strobe, column strobe and write enable lines, together with the bank-select bits and the multiplexed address. In the next cycle it classifies the captured lines as one command. It keeps an open or closed flag for each bank and remembers the row that was activated in each open bank.

For every command it reports a compact command code, the selected bank, the row and column addresses, and a precharge qualifier taken from address bit 10. It raises a one-cycle illegal flag when the command breaks a state rule. These rules cover mode register writes and refreshes while a row is open, commands inside the settling gap that follows a mode register write, row conflicts, and column accesses during an auto-precharge burst. An illegal command changes no state. Data capture, strobe timing and the storage array belong to other blocks.

Top module: `sdram_cmd_decoder`

## Requirements
- R1: While reset is low, and in the first output cycle after it, cmd_o is 0 (no operation), illegal_o is 0 and bank_open_o is all zeros.
- R2: Lines sampled at rising edge k are reported after edge k+1. With chip select low, {ras_n,cas_n,we_n} = 000, 001, 011, 101, 100, 110, 010 and 111 give cmd_o = 1 (mode write), 2 (refresh), 3 (activate), 4 (read), 5 (write), 6 (burst stop), 7 (precharge) and 0 (no operation).
- R3: A command sampled with chip select high is reported as cmd_o = 0 and changes no bank state, whatever the other lines carry.
- R4: The bank-select value b selects bank b: 0 is the first bank, 1 is the bank with only the low bit set, 2 is the bank with only the high bit set, and 3 is the last. bank_o reports b, and bit b of bank_open_o is that bank's state.
- R5: On activate, row_o carries address bits 12..0. On read or write, col_o carries address bits 9..0 and row_o carries the row held by the target bank. Every other command reports 0 on both.
- R6: A legal precharge with address bit 10 high closes every bank and ignores the bank-select bits. With bit 10 low it closes only the selected bank. ap_o reports bit 10 on precharge, read and write, and 0 otherwise.
- R7: A mode write or a refresh while any bank is open is illegal.
- R8: After a legal mode write, any command other than no operation in the following MRS_GAP-1 cycles is illegal.
- R9: An activate to an open bank, or a read or write to a closed bank, is illegal. illegal_o is high for that command's output cycle only, and bank state stays unchanged.
- R10: A legal read or write with address bit 10 high closes its bank BURST_CYC cycles after the command's output cycle.
- R11: A read or write decoded during the BURST_CYC cycles after a legal auto-precharge access is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| ba_i | input | BA_W (2) | Bank select |
| addr_i | input | ROW_W (13) | Multiplexed row/column address |
| cmd_o | output | 3 | Decoded command code |
| bank_o | output | BA_W (2) | Selected bank |
| row_o | output | ROW_W (13) | Row address for activate, open row for read/write |
| col_o | output | COL_W (10) | Column address for read/write |
| ap_o | output | 1 | Auto-precharge or all-bank qualifier (bit 10) |
| illegal_o | output | 1 | Command broke a state rule |
| bank_open_o | output | NUM_BANKS (4) | Open flag per bank |

## Verification
The bench builds the decoder with four banks, a 13-bit row, a 10-bit column, MRS_GAP of 2 and BURST_CYC raised to 3. The longer burst window leaves room for random traffic to land reads, writes, activates and precharges while an auto-precharge is still pending. It also lets the random traffic reach the cycle in which the pending close takes effect. The gap of 2 exposes a single blocked cycle after each mode write, and that cycle is hit both by a directed activate and by random commands that follow a mode write.

// File: rtl/sdram_dec_pkg.sv
package sdram_dec_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_MRS = 3'd1,
    CMD_REF = 3'd2,
    CMD_ACT = 3'd3,
    CMD_RD  = 3'd4,
    CMD_WR  = 3'd5,
    CMD_BST = 3'd6,
    CMD_PRE = 3'd7
  } dec_cmd_e;
endpackage

// File: rtl/cmd_classify.sv
module cmd_classify
  import sdram_dec_pkg::*;
(
  input  logic     cs_n_i,
  input  logic     ras_n_i,
  input  logic     cas_n_i,
  input  logic     we_n_i,
  output dec_cmd_e cmd_o
);
  always_comb begin
    if (cs_n_i) cmd_o = CMD_NOP;  // deselect masks everything
    else begin
      unique case ({ras_n_i, cas_n_i, we_n_i})
        3'b000:  cmd_o = CMD_MRS;
        3'b001:  cmd_o = CMD_REF;
        3'b011:  cmd_o = CMD_ACT;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b110:  cmd_o = CMD_BST;
        3'b010:  cmd_o = CMD_PRE;
        default: cmd_o = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/seq_guard.sv
module seq_guard #(
  parameter int NUM_BANKS = 4,
  parameter int MRS_GAP   = 2,
  parameter int BURST_CYC = 2,
  localparam int BA_W  = $clog2(NUM_BANKS),
  localparam int GAP_W = $clog2(MRS_GAP + 1),
  localparam int AP_W  = $clog2(BURST_CYC + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mrs_set_i,
  input  logic            ap_set_i,
  input  logic [BA_W-1:0] ap_bank_i,
  output logic            gap_busy_o,
  output logic            ap_busy_o,
  output logic            ap_close_o,
  output logic [BA_W-1:0] ap_bank_o
);
  logic [GAP_W-1:0] gap_q;
  logic [AP_W-1:0]  ap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q     <= '0;
      ap_q      <= '0;
      ap_bank_o <= '0;
    end else begin
      if (mrs_set_i)        gap_q <= GAP_W'(MRS_GAP - 1);
      else if (gap_q != '0) gap_q <= gap_q - 1'b1;
      if (ap_set_i) begin
        ap_q      <= AP_W'(BURST_CYC);
        ap_bank_o <= ap_bank_i;
      end else if (ap_q != '0) ap_q <= ap_q - 1'b1;
    end
  end

  assign gap_busy_o = (gap_q != '0);
  assign ap_busy_o  = (ap_q != '0);
  assign ap_close_o = (ap_q == AP_W'(1));

  // R8: a legal mode write opens the settling window
  a_r8_gap_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mrs_set_i && (MRS_GAP > 1)) |=> gap_busy_o);
  // R10: an auto-precharge access arms the close countdown
  a_r10_ap_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ap_set_i |=> (ap_busy_o && ap_bank_o == $past(ap_bank_i)));
endmodule

// File: rtl/bank_tracker.sv
module bank_tracker #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            act_i,
  input  logic                            pre_i,
  input  logic                            pre_all_i,
  input  logic [BA_W-1:0]                 ba_i,
  input  logic [ROW_W-1:0]                row_i,
  input  logic                            close_i,
  input  logic [BA_W-1:0]                 close_bank_i,
  output logic [NUM_BANKS-1:0]            open_o,
  output logic [NUM_BANKS-1:0][ROW_W-1:0] rows_o
);
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic hit, shut;
    assign hit  = (ba_i == BA_W'(g));
    assign shut = (pre_i && (pre_all_i || hit)) || (close_i && close_bank_i == BA_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_o[g] <= 1'b0;
        rows_o[g] <= '0;
      end else if (act_i && hit) begin
        open_o[g] <= 1'b1;
        rows_o[g] <= row_i;
      end else if (shut) begin
        open_o[g] <= 1'b0;
      end
    end
  end

  // R6: all-bank precharge leaves nothing open
  a_r6_pre_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_i && pre_all_i) |=> (open_o == '0));
  // R4: activate opens exactly the selected bank
  a_r4_act_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> open_o[$past(ba_i)]);
endmodule

// File: rtl/sdram_cmd_decoder.sv
module sdram_cmd_decoder
  import sdram_dec_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,
  parameter int AP_BIT    = 10,
  parameter int MRS_GAP   = 2,
  parameter int BURST_CYC = 2,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cs_n_i,
  input  logic                 ras_n_i,
  input  logic                 cas_n_i,
  input  logic                 we_n_i,
  input  logic [BA_W-1:0]      ba_i,
  input  logic [ROW_W-1:0]     addr_i,
  output logic [2:0]           cmd_o,
  output logic [BA_W-1:0]      bank_o,
  output logic [ROW_W-1:0]     row_o,
  output logic [COL_W-1:0]     col_o,
  output logic                 ap_o,
  output logic                 illegal_o,
  output logic [NUM_BANKS-1:0] bank_open_o
);
  logic             cs_q, ras_q, cas_q, we_q;
  logic [BA_W-1:0]  ba_q;
  logic [ROW_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {cs_q, ras_q, cas_q, we_q} <= 4'hF;
      ba_q   <= '0;
      addr_q <= '0;
    end else begin
      {cs_q, ras_q, cas_q, we_q} <= {cs_n_i, ras_n_i, cas_n_i, we_n_i};
      ba_q   <= ba_i;
      addr_q <= addr_i;
    end
  end

  dec_cmd_e dec;
  cmd_classify u_cls (
    .cs_n_i (cs_q), .ras_n_i(ras_q), .cas_n_i(cas_q), .we_n_i(we_q), .cmd_o(dec)
  );

  logic                            gap_busy, ap_busy, ap_close;
  logic [BA_W-1:0]                 ap_bank;
  logic [NUM_BANKS-1:0][ROW_W-1:0] rows;
  logic                            is_rw, bit10, illegal_d, ok;

  assign is_rw = (dec == CMD_RD) || (dec == CMD_WR);
  assign bit10 = addr_q[AP_BIT];

  always_comb begin
    illegal_d = gap_busy && (dec != CMD_NOP);
    unique case (dec)
      CMD_MRS, CMD_REF: if (bank_open_o != '0) illegal_d = 1'b1;
      CMD_ACT:          if (bank_open_o[ba_q]) illegal_d = 1'b1;
      CMD_RD, CMD_WR:   if (!bank_open_o[ba_q] || ap_busy) illegal_d = 1'b1;
      default: ;
    endcase
  end
  assign ok = !illegal_d;

  seq_guard #(.NUM_BANKS(NUM_BANKS), .MRS_GAP(MRS_GAP), .BURST_CYC(BURST_CYC)) u_guard (
    .clk_i, .rst_ni,
    .mrs_set_i (ok && dec == CMD_MRS),
    .ap_set_i  (ok && is_rw && bit10),
    .ap_bank_i (ba_q),
    .gap_busy_o(gap_busy),
    .ap_busy_o (ap_busy),
    .ap_close_o(ap_close),
    .ap_bank_o (ap_bank)
  );

  bank_tracker #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_bank (
    .clk_i, .rst_ni,
    .act_i       (ok && dec == CMD_ACT),
    .pre_i       (ok && dec == CMD_PRE),
    .pre_all_i   (bit10),
    .ba_i        (ba_q),
    .row_i       (addr_q),
    .close_i     (ap_close),
    .close_bank_i(ap_bank),
    .open_o      (bank_open_o),
    .rows_o      (rows)
  );

  dec_cmd_e cmd_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q     <= CMD_NOP;
      illegal_o <= 1'b0;
      bank_o    <= '0;
      row_o     <= '0;
      col_o     <= '0;
      ap_o      <= 1'b0;
    end else begin
      cmd_q     <= dec;
      illegal_o <= illegal_d;
      bank_o    <= ba_q;
      row_o     <= (dec == CMD_ACT) ? addr_q : (is_rw ? rows[ba_q] : '0);
      col_o     <= is_rw ? addr_q[COL_W-1:0] : '0;
      ap_o      <= (is_rw || dec == CMD_PRE) && bit10;
    end
  end
  assign cmd_o = cmd_q;

  // R3: deselected cycle is reported as no operation
  a_r3_cs_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_q |=> (cmd_o == 3'd0));
  // R9: a rejected command leaves bank state alone
  a_r9_illegal_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (illegal_d && !ap_close) |=> $stable(bank_open_o));
  // R7: an accepted mode write saw every bank idle
  a_r7_mrs_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == 3'd1 && !illegal_o) |-> ($past(bank_open_o) == '0));
  // R11: column access during a pending auto-precharge is flagged
  a_r11_ap_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ap_busy && is_rw) |=> illegal_o);
endmodule

// File: tb/sim_sdram_cmd_decoder.sv
module sim_sdram_cmd_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int MG = 2;
  localparam int BC = 3;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [12:0] addr = '0;
  logic [2:0]  cmd_o;
  logic [1:0]  bank_o;
  logic [12:0] row_o;
  logic [9:0]  col_o;
  logic        ap_o, illegal_o;
  logic [3:0]  bank_open_o;

  sdram_cmd_decoder #(.MRS_GAP(MG), .BURST_CYC(BC)) u0 (
    .clk_i(clk), .rst_ni, .cs_n_i(cs_n), .ras_n_i(ras_n), .cas_n_i(cas_n), .we_n_i(we_n),
    .ba_i(ba), .addr_i(addr), .cmd_o, .bank_o, .row_o, .col_o, .ap_o, .illegal_o, .bank_open_o
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  logic [3:0]  m_open = '0;
  logic [12:0] m_row [4] = '{default: '0};
  int m_apc = 0, m_apb = 0, m_gap = 0;
  // command held in the input register
  logic p_cs = 1'b1;
  logic [2:0] p_rcw = 3'b111;
  logic [1:0] p_ba = '0;
  logic [12:0] p_addr = '0;
  // expected outputs
  bit e_valid = 0;
  int e_cmd, e_ill, e_bank, e_row, e_col, e_ap, e_open;
  string e_why, e_ctag;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int code_of(logic cs, logic [2:0] rcw);
    if (cs) return 0;
    case (rcw)
      3'b000: return 1;
      3'b001: return 2;
      3'b011: return 3;
      3'b101: return 4;
      3'b100: return 5;
      3'b110: return 6;
      3'b010: return 7;
      default: return 0;
    endcase
  endfunction

  task automatic model();
    int c = code_of(p_cs, p_rcw);
    bit rw = (c == 4 || c == 5);
    bit ill = 0;
    e_why = "R9";
    if (m_gap != 0 && c != 0) begin ill = 1; e_why = "R8"; end
    if ((c == 1 || c == 2) && m_open != 0) begin ill = 1; e_why = "R7"; end
    if (c == 3 && m_open[p_ba]) begin ill = 1; e_why = "R9"; end
    if (rw && !m_open[p_ba]) begin ill = 1; e_why = "R9"; end
    else if (rw && m_apc != 0) begin ill = 1; e_why = "R11"; end
    e_ctag = p_cs ? "R3" : "R2";
    e_cmd  = c;
    e_ill  = ill;
    e_bank = p_ba;
    e_row  = (c == 3) ? p_addr : (rw ? m_row[p_ba] : 0);
    e_col  = rw ? p_addr[9:0] : 0;
    e_ap   = ((rw || c == 7) && p_addr[10]) ? 1 : 0;
    if (m_apc == 1) m_open[m_apb] = 1'b0;
    if (m_apc > 0) m_apc--;
    if (m_gap > 0) m_gap--;
    if (!ill) begin
      case (c)
        1: m_gap = MG - 1;
        3: begin m_open[p_ba] = 1'b1; m_row[p_ba] = p_addr; end
        7: if (p_addr[10]) m_open = '0; else m_open[p_ba] = 1'b0;
        4, 5: if (p_addr[10]) begin m_apc = BC; m_apb = p_ba; end
        default: ;
      endcase
    end
    e_open = m_open;
  endtask

  task automatic step(logic cs, logic [2:0] rcw, logic [1:0] b, logic [12:0] a);
    @(negedge clk);
    if (e_valid) begin
      check({e_ctag, " cmd_o"}, cmd_o, e_cmd);
      check({e_why, " illegal_o"}, illegal_o, e_ill);
      check("R4 bank_o", bank_o, e_bank);
      check("R5 row_o", row_o, e_row);
      check("R5 col_o", col_o, e_col);
      check("R6 R10 ap_o", ap_o, e_ap);
      check("R6 R9 R10 bank_open_o", bank_open_o, e_open);
    end
    model();
    e_valid = 1;
    cs_n = cs; {ras_n, cas_n, we_n} = rcw; ba = b; addr = a;
    p_cs = cs; p_rcw = rcw; p_ba = b; p_addr = a;
  endtask

  task automatic nop();                           step(0, 3'b111, 0, 0); endtask
  task automatic mrs();                           step(0, 3'b000, 0, 13'h0031); endtask
  task automatic refr();                          step(0, 3'b001, 0, 0); endtask
  task automatic act(logic [1:0] b, logic [12:0] r); step(0, 3'b011, b, r); endtask
  task automatic rd(logic [1:0] b, logic [9:0] c, logic apb); step(0, 3'b101, b, {2'b00, apb, c}); endtask
  task automatic wr(logic [1:0] b, logic [9:0] c, logic apb); step(0, 3'b100, b, {2'b00, apb, c}); endtask
  task automatic pre(logic [1:0] b, logic all);   step(0, 3'b010, b, {2'b00, all, 10'h0}); endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 cmd_o", cmd_o, 0);
    check("R1 illegal_o", illegal_o, 0);
    check("R1 bank_open_o", bank_open_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 cmd_o after release", cmd_o, 0);
    check("R1 bank_open_o after release", bank_open_o, 0);

    nop(); nop();
    mrs();                    // R7 legal, banks idle
    act(2'd1, 13'h1ABC);      // R8 inside gap: illegal
    nop();
    act(2'd1, 13'h1ABC);      // R4 R5 opens bank 1
    mrs();                    // R7 illegal
    refr();                   // R7 illegal
    act(2'd1, 13'h0123);      // R9 already open
    rd(2'd2, 10'h055, 0);     // R9 closed bank
    step(1, 3'b011, 2'd2, 13'h0777); // R3 deselected activate
    rd(2'd1, 10'h155, 0);     // R5 column + open row
    wr(2'd1, 10'h3FF, 1);     // R10 write with auto precharge
    rd(2'd1, 10'h001, 0);     // R11 blocked
    wr(2'd1, 10'h002, 0);     // R11 blocked
    nop(); nop(); nop();      // R10 bank 1 closes
    act(2'd0, 13'h0F0F);
    act(2'd3, 13'h1F00);
    act(2'd2, 13'h0002);
    pre(2'd0, 0);             // R6 single bank
    pre(2'd1, 1);             // R6 all banks, bank bits ignored
    refr();                   // R7 legal now
    step(0, 3'b110, 2'd3, 0); // R2 burst stop
    nop();

    for (int i = 0; i < 4000; i++) begin
      int r = $urandom % 16;
      logic [1:0] b = 2'($urandom);
      logic [12:0] a = 13'($urandom);
      a[10] = (($urandom % 4) == 0);
      case (r)
        6:      step(1, 3'($urandom), b, a);
        7, 8:   step(0, 3'b011, b, a);
        9:      step(0, 3'b101, b, a);
        10:     step(0, 3'b100, b, a);
        11, 15: step(0, 3'b010, b, a);
        12:     step(0, 3'b000, b, a);
        13:     step(0, 3'b001, b, a);
        14:     step(0, 3'b110, b, a);
        default: step(0, 3'b111, b, a);
      endcase
    end
    nop(); nop();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule